// File: doc/BRIEF.md
# Delay-Slot Branch Sequencer

This block owns the program counter of a simple in-order pipeline and decides where execution goes after each retired instruction. It evaluates conditional branches against zero, unconditional jumps (relative or absolute, with an optional link) and the three return flavours. It also sequences an optional single delay slot, so that the redirect takes effect only after the slot instruction has retired.

An upstream decoder classifies each instruction and presents the raw instruction word, the `ra` register value, the resolved operand B and an immediate-prefix flag, together with a step strobe when the instruction retires. The block answers in the same cycle with a link-write request and, on the cycle the program counter is redirected, a taken pulse and a one-cycle pulse naming the status update a return must apply. The updated program counter appears on `pc_o` after the clock edge. Illegal branch placement, break vectors and misaligned program counters are flagged for the exception logic.

Top module: `branch_seq_unit`

## Requirements
- R1: After reset `pc_o` equals the RESET_PC parameter (0x100 by default), no branch is pending, and every pulse output is low.
- R2: A step with no branch pending and class 0 (not a branch) advances `pc_o` by 4 after the edge; a cycle without `step_i` leaves `pc_o` unchanged.
- R3: Class 1 is a conditional branch. Its code in instruction bits 23:21 compares `ra_i`, read as a signed value, with zero: 0 equal, 1 not equal, 2 less, 3 less-or-equal, 4 greater-or-equal, 5 greater. Codes 6 and 7 are never taken. The target is the branch PC plus `opb_i`.
- R4: A conditional branch with bit 25 set has one delay slot, and the redirect happens on the step of the slot instruction. With bit 25 clear the redirect happens on the branch's own step. When the branch is not taken, execution continues sequentially, and `taken_o` pulses only on the redirect step of a taken branch.
- R5: Class 2 is an unconditional branch and is always taken. Bit 19 set gives the absolute target `opb_i`; bit 19 clear gives the branch PC plus `opb_i`. Bit 20 requests a delay slot.
- R6: An unconditional branch with bit 18 set raises `link_we_o` in its step cycle, with `link_rd_o` equal to bits 25:21 and `link_pc_o` equal to the branch's own PC.
- R7: Class 3 is a return with target `ra_i` plus `opb_i`. It always has a delay slot. Bits 21, 22 and 23 select the interrupt, break and exception returns, which appear as `ret_pulse_o` bits 0, 1 and 2 only on the step that completes the slot.
- R8: `brk_evt_o` pulses for an accepted unconditional branch with bits 19 and 18 both set, immediate bits 15:0 equal to 0x8 or 0x18, and `imm_pfx_i` low.
- R9: A branch or return of any class that steps while a delay slot is pending raises `illegal_o`. It is otherwise ignored: it writes no link and leaves the pending redirect unchanged.
- R10: `misalign_o` is high exactly when the two low bits of `pc_o` are not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Instruction at `pc_o` retires this cycle |
| class_i | input | 2 | 0 other, 1 conditional, 2 unconditional, 3 return |
| ins_i | input | 32 | Instruction word |
| ra_i | input | XLEN | Value of register ra |
| opb_i | input | XLEN | Resolved operand B |
| imm_pfx_i | input | 1 | An immediate prefix precedes this instruction |
| pc_o | output | XLEN | Current program counter |
| taken_o | output | 1 | Taken redirect applied on this step |
| link_we_o | output | 1 | Link register write request |
| link_rd_o | output | 5 | Link destination register |
| link_pc_o | output | XLEN | Value to link (branch PC) |
| ret_pulse_o | output | 3 | {exception, break, interrupt} return update |
| brk_evt_o | output | 1 | Break vector jump detected |
| illegal_o | output | 1 | Branch placed in a delay slot |
| misalign_o | output | 1 | Program counter not word aligned |

## Verification
On every cycle, the assertions check that the stored slot countdown never exceeds one, that the PC holds without a step and advances by one word on plain steps, that return pulses come only out of a pending slot, and that an illegal branch never links. Only the scenarios can show that each condition code is decided correctly for negative, zero and positive `ra_i`, that targets and delayed redirects land on the right address after the slot, and that the break vector check depends on the prefix flag.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    typedef enum logic [1:0] {
        CLS_OTHER = 2'd0,
        CLS_COND  = 2'd1,
        CLS_JUMP  = 2'd2,
        CLS_RET   = 2'd3
    } ins_class_e;

    // Instruction field positions
    localparam int CC_LSB    = 21;
    localparam int CC_W      = 3;
    localparam int CDLY_BIT  = 25;
    localparam int JDLY_BIT  = 20;
    localparam int JABS_BIT  = 19;
    localparam int JLNK_BIT  = 18;
    localparam int RD_LSB    = 21;
    localparam int RD_W      = 5;
    localparam int RSEL_LSB  = 21;
    localparam int RSEL_W    = 3;
    localparam int IMM_W     = 16;

    // Countdown values loaded by an accepted branch
    localparam logic [1:0] CNT_SLOT   = 2'd2;
    localparam logic [1:0] CNT_NOSLOT = 2'd1;

endpackage

// File: rtl/bsu_cond_eval.sv
module bsu_cond_eval #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]          ra_i,
    input  logic [bsu_pkg::CC_W-1:0] cc_i,
    output logic                     take_o
);
    logic is_zero;
    logic is_neg;

    assign is_zero = (ra_i == '0);
    assign is_neg  = ra_i[XLEN-1];

    always_comb begin
        case (cc_i)
            3'd0:    take_o = is_zero;
            3'd1:    take_o = !is_zero;
            3'd2:    take_o = is_neg;
            3'd3:    take_o = is_neg || is_zero;
            3'd4:    take_o = !is_neg;
            3'd5:    take_o = !is_neg && !is_zero;
            default: take_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bsu_decode.sv
module bsu_decode #(
    parameter int          XLEN  = 32,
    parameter int          IW    = 32,
    parameter logic [15:0] BRK_A = 16'h0008,
    parameter logic [15:0] BRK_B = 16'h0018
) (
    input  logic [1:0]                     class_i,
    input  logic [IW-1:0]                  ins_i,
    input  logic [XLEN-1:0]                ra_i,
    input  logic [XLEN-1:0]                opb_i,
    input  logic [XLEN-1:0]                pc_i,
    input  logic                           imm_pfx_i,
    output logic                           is_br_o,
    output logic                           dly_o,
    output logic                           tkn_o,
    output logic [XLEN-1:0]                tgt_o,
    output logic [bsu_pkg::RSEL_W-1:0]     ret_o,
    output logic                           link_o,
    output logic [bsu_pkg::RD_W-1:0]       rd_o,
    output logic                           brk_o
);
    import bsu_pkg::*;

    logic                 cond_take;
    logic [IMM_W-1:0]     imm16;
    logic [XLEN-1:0]      rel_tgt;

    assign imm16   = ins_i[IMM_W-1:0];
    assign rel_tgt = pc_i + opb_i;
    assign rd_o    = ins_i[RD_LSB +: RD_W];

    bsu_cond_eval #(.XLEN(XLEN)) u_cond (
        .ra_i   (ra_i),
        .cc_i   (ins_i[CC_LSB +: CC_W]),
        .take_o (cond_take)
    );

    always_comb begin
        is_br_o = 1'b0;
        dly_o   = 1'b0;
        tkn_o   = 1'b0;
        tgt_o   = rel_tgt;
        ret_o   = '0;
        link_o  = 1'b0;
        brk_o   = 1'b0;
        case (ins_class_e'(class_i))
            CLS_COND: begin
                is_br_o = 1'b1;
                dly_o   = ins_i[CDLY_BIT];
                tkn_o   = cond_take;
            end
            CLS_JUMP: begin
                is_br_o = 1'b1;
                dly_o   = ins_i[JDLY_BIT];
                tkn_o   = 1'b1;
                tgt_o   = ins_i[JABS_BIT] ? opb_i : rel_tgt;
                link_o  = ins_i[JLNK_BIT];
                brk_o   = ins_i[JABS_BIT] && ins_i[JLNK_BIT] && !imm_pfx_i
                          && (imm16 == BRK_A || imm16 == BRK_B);
            end
            CLS_RET: begin
                is_br_o = 1'b1;
                dly_o   = 1'b1;
                tkn_o   = 1'b1;
                tgt_o   = ra_i + opb_i;
                ret_o   = ins_i[RSEL_LSB +: RSEL_W];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/branch_seq_unit.sv
module branch_seq_unit #(
    parameter int              XLEN       = 32,
    parameter int              INSN_BYTES = 4,
    parameter logic [XLEN-1:0] RESET_PC   = 32'h0000_0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    input  logic [1:0]      class_i,
    input  logic [31:0]     ins_i,
    input  logic [XLEN-1:0] ra_i,
    input  logic [XLEN-1:0] opb_i,
    input  logic            imm_pfx_i,
    output logic [XLEN-1:0] pc_o,
    output logic            taken_o,
    output logic            link_we_o,
    output logic [4:0]      link_rd_o,
    output logic [XLEN-1:0] link_pc_o,
    output logic [2:0]      ret_pulse_o,
    output logic            brk_evt_o,
    output logic            illegal_o,
    output logic            misalign_o
);
    import bsu_pkg::*;

    localparam int              ALIGN_W = $clog2(INSN_BYTES);
    localparam logic [XLEN-1:0] PC_INC  = XLEN'(INSN_BYTES);

    typedef struct packed {
        logic [XLEN-1:0]   pc;
        logic [1:0]        cnt;
        logic [XLEN-1:0]   tgt;
        logic              tkn;
        logic [RSEL_W-1:0] ret;
    } seq_st_t;

    localparam seq_st_t RST_ST = '{pc: RESET_PC, cnt: 2'd0, tgt: '0,
                                   tkn: 1'b0, ret: '0};

    seq_st_t st_d, st_q;

    logic              dec_is_br, dec_dly, dec_tkn, dec_link, dec_brk;
    logic [XLEN-1:0]   dec_tgt;
    logic [RSEL_W-1:0] dec_ret;
    logic [RD_W-1:0]   dec_rd;

    bsu_decode #(.XLEN(XLEN), .IW(32)) u_dec (
        .class_i   (class_i),
        .ins_i     (ins_i),
        .ra_i      (ra_i),
        .opb_i     (opb_i),
        .pc_i      (st_q.pc),
        .imm_pfx_i (imm_pfx_i),
        .is_br_o   (dec_is_br),
        .dly_o     (dec_dly),
        .tkn_o     (dec_tkn),
        .tgt_o     (dec_tgt),
        .ret_o     (dec_ret),
        .link_o    (dec_link),
        .rd_o      (dec_rd),
        .brk_o     (dec_brk)
    );

    // Effective branch context for this step
    logic [1:0]        eff_cnt, cnt_after;
    logic [XLEN-1:0]   eff_tgt;
    logic              eff_tkn;
    logic [RSEL_W-1:0] eff_ret;
    logic              accept;

    always_comb begin
        st_d        = st_q;
        taken_o     = 1'b0;
        link_we_o   = 1'b0;
        link_rd_o   = '0;
        link_pc_o   = '0;
        ret_pulse_o = '0;
        brk_evt_o   = 1'b0;
        illegal_o   = 1'b0;
        accept      = dec_is_br && (st_q.cnt == 2'd0);
        eff_cnt     = st_q.cnt;
        eff_tgt     = st_q.tgt;
        eff_tkn     = st_q.tkn;
        eff_ret     = st_q.ret;
        cnt_after   = 2'd0;
        if (step_i) begin
            if (dec_is_br && !accept) begin
                illegal_o = 1'b1;
            end
            if (accept) begin
                eff_cnt   = dec_dly ? CNT_SLOT : CNT_NOSLOT;
                eff_tgt   = dec_tgt;
                eff_tkn   = dec_tkn;
                eff_ret   = dec_ret;
                link_we_o = dec_link;
                link_rd_o = dec_link ? dec_rd : '0;
                link_pc_o = dec_link ? st_q.pc : '0;
                brk_evt_o = dec_brk;
            end
            cnt_after = (eff_cnt == 2'd0) ? 2'd0 : eff_cnt - 2'd1;
            if (eff_cnt != 2'd0 && cnt_after == 2'd0) begin
                st_d.pc     = eff_tkn ? eff_tgt : st_q.pc + PC_INC;
                taken_o     = eff_tkn;
                ret_pulse_o = eff_ret;
                st_d.cnt    = 2'd0;
                st_d.tgt    = '0;
                st_d.tkn    = 1'b0;
                st_d.ret    = '0;
            end else begin
                st_d.pc  = st_q.pc + PC_INC;
                st_d.cnt = cnt_after;
                st_d.tgt = eff_tgt;
                st_d.tkn = eff_tkn;
                st_d.ret = eff_ret;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign pc_o       = st_q.pc;
    assign misalign_o = |st_q.pc[ALIGN_W-1:0];

    // Stored countdown is at most one once the branch step has counted
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= 2'd1);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(pc_o));

    p_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && st_q.cnt == 2'd0 && class_i == CLS_OTHER)
        |=> pc_o == $past(pc_o) + PC_INC);

    p_ret_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_pulse_o != '0) |-> (st_q.cnt == 2'd1));

    p_ill_nolink_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!link_we_o && !brk_evt_o));

    p_ill_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> (pc_o == $past(st_q.tkn ? st_q.tgt : st_q.pc + PC_INC)));
endmodule

// File: tb/tb_branch_seq_unit.sv
module tb_branch_seq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic [1:0]  class_i = 2'd0;
    logic [31:0] ins_i = '0;
    logic [31:0] ra_i = '0;
    logic [31:0] opb_i = '0;
    logic        imm_pfx_i = 1'b0;
    logic [31:0] pc_o;
    logic        taken_o, link_we_o, brk_evt_o, illegal_o, misalign_o;
    logic [4:0]  link_rd_o;
    logic [31:0] link_pc_o;
    logic [2:0]  ret_pulse_o;

    branch_seq_unit dut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .class_i(class_i),
        .ins_i(ins_i), .ra_i(ra_i), .opb_i(opb_i), .imm_pfx_i(imm_pfx_i),
        .pc_o(pc_o), .taken_o(taken_o), .link_we_o(link_we_o),
        .link_rd_o(link_rd_o), .link_pc_o(link_pc_o),
        .ret_pulse_o(ret_pulse_o), .brk_evt_o(brk_evt_o),
        .illegal_o(illegal_o), .misalign_o(misalign_o)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    localparam int K_PC = 0, K_TKN = 1, K_LINK = 2, K_LWE = 3,
                   K_RET = 4, K_BRK = 5, K_ILL = 6, K_MIS = 7;

    typedef struct {
        int          when;
        int          kind;
        logic [63:0] exp;
        string       req;
    } item_t;

    item_t sbq[$];
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    function automatic logic [63:0] observe(int k);
        case (k)
            K_PC:    return 64'(pc_o);
            K_TKN:   return 64'(taken_o);
            K_LINK:  return 64'({link_we_o, link_rd_o, link_pc_o});
            K_LWE:   return 64'(link_we_o);
            K_RET:   return 64'(ret_pulse_o);
            K_BRK:   return 64'(brk_evt_o);
            K_ILL:   return 64'(illegal_o);
            default: return 64'(misalign_o);
        endcase
    endfunction

    // Monitor: compares queued expectations in their due cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sbq.size() > 0 && sbq[0].when <= cyc) begin
                item_t it;
                logic [63:0] got;
                it  = sbq.pop_front();
                got = observe(it.kind);
                n_run++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%0h expected=%0h",
                             it.req, it.kind, got, it.exp);
                end
            end
        end
    end

    task automatic exp_now(int k, logic [63:0] v, string r);
        sbq.push_back('{when: cyc, kind: k, exp: v, req: r});
    endtask

    task automatic exp_next(int k, logic [63:0] v, string r);
        sbq.push_back('{when: cyc + 1, kind: k, exp: v, req: r});
    endtask

    task automatic drive(logic [1:0] c, logic [31:0] w, logic [31:0] ra,
                         logic [31:0] ob, logic pf);
        @(negedge clk);
        step_i = 1'b1; class_i = c; ins_i = w;
        ra_i = ra; opb_i = ob; imm_pfx_i = pf;
    endtask

    task automatic idle();
        @(negedge clk);
        step_i = 1'b0; class_i = 2'd0; ins_i = '0;
        ra_i = '0; opb_i = '0; imm_pfx_i = 1'b0;
    endtask

    function automatic logic [31:0] w_cond(bit slot, int cc);
        return (32'(slot) << 25) | (32'(cc) << 21);
    endfunction

    function automatic logic [31:0] w_jump(bit slot, bit ab, bit lk, int rd, int imm);
        return (32'(rd) << 21) | (32'(slot) << 20) | (32'(ab) << 19)
             | (32'(lk) << 18) | 32'(imm & 16'hFFFF);
    endfunction

    function automatic logic [31:0] w_ret(int sel);
        return 32'(sel) << 21;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        exp_now(K_PC, 64'h100, "R1");
        exp_now(K_TKN, 0, "R1");
        exp_now(K_RET, 0, "R1");
        exp_now(K_MIS, 0, "R1");
        // R2 sequential and hold
        drive(2'd0, 32'h0, 0, 0, 0);   exp_next(K_PC, 64'h104, "R2");
        idle();                        exp_next(K_PC, 64'h104, "R2");
        // R3/R4 equal, no slot, taken
        drive(2'd1, w_cond(0, 0), 0, 32'h20, 0);
        exp_now(K_TKN, 1, "R4"); exp_next(K_PC, 64'h124, "R3");
        // R3 not-equal with ra zero: not taken
        drive(2'd1, w_cond(0, 1), 0, 32'h20, 0);
        exp_now(K_TKN, 0, "R3"); exp_next(K_PC, 64'h128, "R3");
        // R4 less-than with slot, negative ra
        drive(2'd1, w_cond(1, 2), 32'hFFFF_FFFB, 32'hFFFF_FFD8, 0);
        exp_now(K_TKN, 0, "R4"); exp_next(K_PC, 64'h12C, "R4");
        drive(2'd0, 32'h0, 0, 0, 0);
        exp_now(K_TKN, 1, "R4"); exp_next(K_PC, 64'h100, "R4");
        // R4 greater-or-equal with slot, negative ra: not taken
        drive(2'd1, w_cond(1, 4), 32'hFFFF_FFFF, 32'h80, 0);
        exp_next(K_PC, 64'h104, "R4");
        drive(2'd0, 32'h0, 0, 0, 0);
        exp_now(K_TKN, 0, "R4"); exp_next(K_PC, 64'h108, "R4");
        // R3 code 7 never taken
        drive(2'd1, w_cond(0, 7), 0, 32'h80, 0);
        exp_now(K_TKN, 0, "R3"); exp_next(K_PC, 64'h10C, "R3");
        // R3 greater than, positive ra
        drive(2'd1, w_cond(0, 5), 1, 32'h10, 0);
        exp_now(K_TKN, 1, "R3"); exp_next(K_PC, 64'h11C, "R3");
        // R5/R6 relative linking jump
        drive(2'd2, w_jump(0, 0, 1, 15, 0), 0, 32'h40, 0);
        exp_now(K_LINK, {26'd0, 1'b1, 5'd15, 32'h11C}, "R6");
        exp_next(K_PC, 64'h15C, "R5");
        // R5 absolute jump with slot, R9 branch in slot
        drive(2'd2, w_jump(1, 1, 0, 0, 0), 0, 32'h200, 0);
        exp_now(K_TKN, 0, "R5"); exp_next(K_PC, 64'h160, "R5");
        drive(2'd2, w_jump(0, 0, 1, 3, 0), 0, 32'h40, 0);
        exp_now(K_ILL, 1, "R9"); exp_now(K_LWE, 0, "R9");
        exp_next(K_PC, 64'h200, "R9");
        // R8 break vector without prefix
        drive(2'd2, w_jump(0, 1, 1, 15, 16'h18), 0, 32'h18, 0);
        exp_now(K_BRK, 1, "R8"); exp_now(K_ILL, 0, "R9");
        exp_next(K_PC, 64'h18, "R5");
        // R8 prefix suppresses break
        drive(2'd2, w_jump(0, 1, 1, 15, 16'h8), 0, 32'h300, 1);
        exp_now(K_BRK, 0, "R8"); exp_next(K_PC, 64'h300, "R5");
        // R7 exception return
        drive(2'd3, w_ret(3'b100), 32'h400, 32'h10, 0);
        exp_now(K_RET, 0, "R7"); exp_next(K_PC, 64'h304, "R7");
        drive(2'd0, 32'h0, 0, 0, 0);
        exp_now(K_RET, 3'b100, "R7"); exp_next(K_PC, 64'h410, "R7");
        // R7 interrupt return
        drive(2'd3, w_ret(3'b001), 32'h500, 32'h0, 0);
        exp_next(K_PC, 64'h414, "R7");
        drive(2'd0, 32'h0, 0, 0, 0);
        exp_now(K_RET, 3'b001, "R7"); exp_next(K_PC, 64'h500, "R7");
        // R10 misaligned target
        drive(2'd2, w_jump(0, 0, 0, 0, 0), 0, 32'h2, 0);
        exp_next(K_PC, 64'h502, "R10"); exp_next(K_MIS, 1, "R10");
        drive(2'd2, w_jump(0, 1, 0, 0, 0), 0, 32'h600, 0);
        exp_next(K_PC, 64'h600, "R10"); exp_next(K_MIS, 0, "R10");
        repeat (3) idle();
        @(negedge clk); #2;
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule